// File: doc/BRIEF.md
# Fuse Read Controller

A register-mapped controller that returns words from a 512-byte one-time-programmable fuse array. Software picks a word address, latches it with a strobe bit, powers the array up, enables automatic read and issues a start strobe. The block then raises a busy flag and fetches the word over a fixed number of cycles. It deposits the word in a read-only data register and drops busy. Software polls busy and then reads the data register.

The fuse contents come from a compile-time seed through a fixed formula, so the array is an elaborated ROM. The word width is 1 or 4 bytes. The word address is the byte offset divided by the word width, and bytes are packed little-endian into the data register. The fuse-programming controls share the same control register and are only stored.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, which is power-down bit 27 set and everything else clear. The data register (0x08) and the auxiliary register (0x10) read 0.
- R2: The control register reads back the last written address field [10:0], program-enable [12], program-go [13], program byte [23:16], read-enable [24] and power-down [27]. Busy shows in [26]. Bits 11, 14 and 25 and all other bits read 0.
- R3: The fetch address is taken from bits [10:0] only by a control write with bit 11 set. A later change to the address field without bit 11, including one during a fetch, does not alter the word fetched.
- R4: A control write starts a fetch when all of these hold: bit 25 is 1, the previous control write had bit 25 at 0, bit 24 is 1 and bit 27 is 0 in that same write, and no fetch is running. Busy then reads 1 from the very next cycle.
- R5: Busy stays high for exactly LATENCY cycles (default 8). In the cycle it drops, the data register holds the fetched word. The data register changes at no other time.
- R6: Fuse byte i (0..511) equals ((i*37 + SEED) mod 256), inverted when i >= 256, with SEED defaulting to 0x5A. A word at address a holds bytes a*W .. a*W+W-1, lowest byte in bits [7:0], with zeros above 8*W bits.
- R7: A word address of 512/W or more fetches all zeros.
- R8: Start writes are ignored while power-down is set, while read-enable is clear, when bit 25 was already 1 in the previous control write, or while busy. An ignored start neither raises busy nor changes the data register.
- R9: The auxiliary register at 0x10 stores only its encrypt-enable bit 10. All of its other bits read 0.
- R10: Unmapped offsets read 0, and writes to the data register have no effect.
- R11: rdata_o is 0 in any cycle without a read request (req_i low or we_i high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid combinationally in the request cycle |

## Verification
Register writes take effect at the clock edge that ends the write cycle, and reads return state combinationally within their own request cycle. Busy is therefore visible in the read cycle right after the start write. The fetched word appears LATENCY edges after that write, in the same cycle busy reads 0. The bench keeps a behavioural model that advances at each rising edge with the same counting. It compares every output a quarter period after the edge. Directed reads sample a quarter period after the driving falling edge, so each check sees the state left by the last edge. Counting busy cycles by polling yields exactly LATENCY.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DATA = 5'h08;
  localparam logic [REG_AW-1:0] OFS_AUX  = 5'h10;

  localparam int FLD_AW    = 11;
  localparam int B_ASET    = 11;
  localparam int B_PEN     = 12;
  localparam int B_PGO     = 13;
  localparam int B_PBUSY   = 14;
  localparam int B_PBYTE   = 16;
  localparam int B_RDEN    = 24;
  localparam int B_RGO     = 25;
  localparam int B_RBUSY   = 26;
  localparam int B_PD      = 27;
  localparam int B_ENC     = 10;

  // seeded fill pattern of the fuse array; upper half inverted
  function automatic logic [7:0] fuse_byte(input int unsigned idx, input logic [7:0] seed);
    logic [7:0] v;
    v = 8'(idx * 37 + 32'(seed));
    if (idx >= 256) v = ~v;
    return v;
  endfunction
endpackage

// File: rtl/fuse_rom.sv
module fuse_rom import fuse_rd_pkg::*; #(
  parameter int         WORD_BYTES  = 4,
  parameter int         ARRAY_BYTES = 512,
  parameter logic [7:0] INIT_SEED   = 8'h5A
) (
  input  logic [FLD_AW-1:0] word_addr_i,
  output logic [31:0]       word_o
);
  localparam int NUM_WORDS = ARRAY_BYTES / WORD_BYTES;

  initial assert (WORD_BYTES == 1 || WORD_BYTES == 4);

  always_comb begin
    word_o = '0;
    if (32'(word_addr_i) < NUM_WORDS) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        word_o[8*b +: 8] = fuse_byte(32'(word_addr_i) * WORD_BYTES + b, INIT_SEED);
      end
    end
  end
endmodule

// File: rtl/fuse_regs.sv
module fuse_regs import fuse_rd_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_aux_i,
  input  logic [31:0]       wdata_i,
  output logic [FLD_AW-1:0] addr_fld_o,
  output logic [FLD_AW-1:0] lat_addr_o,
  output logic              pen_o,
  output logic              pgo_o,
  output logic [7:0]        pbyte_o,
  output logic              rd_en_o,
  output logic              pd_o,
  output logic              enc_en_o,
  output logic              start_req_o
);
  logic go_q;
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:28], wdata_i[B_RBUSY], wdata_i[15:14]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_fld_o <= '0;
      lat_addr_o <= '0;
      pen_o      <= 1'b0;
      pgo_o      <= 1'b0;
      pbyte_o    <= '0;
      rd_en_o    <= 1'b0;
      pd_o       <= 1'b1;
      enc_en_o   <= 1'b0;
      go_q       <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        addr_fld_o <= wdata_i[FLD_AW-1:0];
        if (wdata_i[B_ASET]) lat_addr_o <= wdata_i[FLD_AW-1:0];
        pen_o   <= wdata_i[B_PEN];
        pgo_o   <= wdata_i[B_PGO];
        pbyte_o <= wdata_i[B_PBYTE +: 8];
        rd_en_o <= wdata_i[B_RDEN];
        pd_o    <= wdata_i[B_PD];
        go_q    <= wdata_i[B_RGO];
      end
      if (wr_aux_i) enc_en_o <= wdata_i[B_ENC];
    end
  end

  // edge-qualified start, gated by the enables carried in the same write
  assign start_req_o = wr_ctrl_i & wdata_i[B_RGO] & ~go_q & wdata_i[B_RDEN] & ~wdata_i[B_PD];

  p_latch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ctrl_i && wdata_i[B_ASET]) |=> $stable(lat_addr_o));
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq import fuse_rd_pkg::*; #(
  parameter int LATENCY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic [FLD_AW-1:0] addr_i,
  input  logic [31:0]       rom_word_i,
  output logic [FLD_AW-1:0] rom_addr_o,
  output logic              busy_o,
  output logic [31:0]       data_o
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0] cnt_q;

  initial assert (LATENCY >= 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      rom_addr_o <= '0;
      data_o     <= '0;
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o <= 1'b0;
        data_o <= rom_word_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start_req_i) begin
      busy_o     <= 1'b1;
      cnt_q      <= CNT_W'(LATENCY - 1);
      rom_addr_o <= addr_i;
    end
  end

  // checker: length of the busy window
  int unsigned busy_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len <= 0;
    else         busy_len <= busy_o ? busy_len + 1 : 0;
  end

  p_go_sets_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_i && !busy_o) |=> busy_o);
  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == LATENCY));
  p_data_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $fell(busy_o));
  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rom_addr_o));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl import fuse_rd_pkg::*; #(
  parameter int         WORD_BYTES  = 4,
  parameter int         ARRAY_BYTES = 512,
  parameter int         LATENCY     = 8,
  parameter logic [7:0] INIT_SEED   = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic              wr_ctrl, wr_aux, rd_req;
  logic [FLD_AW-1:0] addr_fld, lat_addr, rom_addr;
  logic              pen, pgo, rd_en, pd, enc_en, start_req, busy;
  logic [7:0]        pbyte;
  logic [31:0]       rom_word, data_q;

  assign rd_req  = req_i & ~we_i;
  assign wr_ctrl = req_i & we_i & (addr_i == OFS_CTRL);
  assign wr_aux  = req_i & we_i & (addr_i == OFS_AUX);

  fuse_regs u_regs (
    .clk_i, .rst_ni,
    .wr_ctrl_i   (wr_ctrl),
    .wr_aux_i    (wr_aux),
    .wdata_i     (wdata_i),
    .addr_fld_o  (addr_fld),
    .lat_addr_o  (lat_addr),
    .pen_o       (pen),
    .pgo_o       (pgo),
    .pbyte_o     (pbyte),
    .rd_en_o     (rd_en),
    .pd_o        (pd),
    .enc_en_o    (enc_en),
    .start_req_o (start_req)
  );

  fuse_rd_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i, .rst_ni,
    .start_req_i (start_req),
    .addr_i      (lat_addr),
    .rom_word_i  (rom_word),
    .rom_addr_o  (rom_addr),
    .busy_o      (busy),
    .data_o      (data_q)
  );

  fuse_rom #(.WORD_BYTES(WORD_BYTES), .ARRAY_BYTES(ARRAY_BYTES), .INIT_SEED(INIT_SEED)) u_rom (
    .word_addr_i (rom_addr),
    .word_o      (rom_word)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_req) begin
      unique case (addr_i)
        OFS_CTRL: begin
          rdata_o[FLD_AW-1:0]   = addr_fld;
          rdata_o[B_PEN]        = pen;
          rdata_o[B_PGO]        = pgo;
          rdata_o[B_PBYTE +: 8] = pbyte;
          rdata_o[B_RDEN]       = rd_en;
          rdata_o[B_RBUSY]      = busy;
          rdata_o[B_PD]         = pd;
        end
        OFS_DATA: rdata_o = data_q;
        OFS_AUX:  rdata_o[B_ENC] = enc_en;
        default:  rdata_o = '0;
      endcase
    end
  end

  p_rd_start_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_ctrl && wdata_i[B_RGO] && wdata_i[B_RDEN] && !wdata_i[B_PD]));
  p_pd_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd && !wr_ctrl) |=> !$rose(busy));
  p_strobes_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == OFS_CTRL) |-> (!rdata_o[B_ASET] && !rdata_o[B_RGO] && !rdata_o[B_PBUSY]));
  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |-> (rdata_o == '0));
endmodule

// File: tb/fuse_rd_ctrl_tb_top.sv
module fuse_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;
  localparam int WB  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_rd_ctrl #(.WORD_BYTES(WB), .LATENCY(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // ---- behavioural reference ----
  function automatic logic [31:0] ref_word(int a);
    logic [31:0] w = '0;
    if (a < 512 / WB)
      for (int b = 0; b < WB; b++) begin
        int i = a * WB + b;
        int v = (i * 37 + 'h5A) % 256;
        if (i >= 256) v = v ^ 255;
        w[8*b +: 8] = v[7:0];
      end
    return w;
  endfunction

  int m_fld, m_lat, m_pen, m_pgo, m_pb, m_ren, m_pd, m_enc, m_goq, m_busy, m_rem, m_cur;
  logic [31:0] m_data;

  always @(posedge clk or negedge rst_n) begin : model
    int ob;
    bit go;
    if (!rst_n) begin
      m_fld = 0; m_lat = 0; m_pen = 0; m_pgo = 0; m_pb = 0; m_ren = 0;
      m_pd = 1; m_enc = 0; m_goq = 0; m_busy = 0; m_rem = 0; m_cur = 0; m_data = '0;
    end else begin
      ob = m_busy;
      if (ob != 0) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_data = ref_word(m_cur); end
      end
      if (req && we && addr == 5'h04) begin
        go = wdata[25] && m_goq == 0 && wdata[24] && !wdata[27] && ob == 0;
        if (go) begin m_busy = 1; m_rem = LAT; m_cur = m_lat; end
        m_fld = int'(wdata[10:0]);
        if (wdata[11]) m_lat = int'(wdata[10:0]);
        m_pen = int'(wdata[12]); m_pgo = int'(wdata[13]); m_pb = int'(wdata[23:16]);
        m_ren = int'(wdata[24]); m_pd = int'(wdata[27]); m_goq = int'(wdata[25]);
      end
      if (req && we && addr == 5'h10) m_enc = int'(wdata[10]);
    end
  end

  function automatic logic [31:0] ref_rd();
    logic [31:0] r = '0;
    if (req && !we) begin
      if (addr == 5'h04) begin
        r[10:0] = m_fld[10:0]; r[12] = m_pen[0]; r[13] = m_pgo[0]; r[23:16] = m_pb[7:0];
        r[24] = m_ren[0]; r[26] = m_busy[0]; r[27] = m_pd[0];
      end else if (addr == 5'h08) r = m_data;
      else if (addr == 5'h10) r[10] = m_enc[0];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      if (!req || we)        chk("R11", rdata, ref_rd());
      else if (addr == 5'h04) chk("R2", rdata, ref_rd());
      else if (addr == 5'h08) chk("R5", rdata, ref_rd());
      else if (addr == 5'h10) chk("R9", rdata, ref_rd());
      else                    chk("R10", rdata, ref_rd());
    end
  end

  // ---- bus tasks (entered and left at a falling edge) ----
  task automatic wr(logic [4:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #(CLK_PERIOD/4);
    d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  localparam logic [31:0] RDEN = 32'h0100_0000, GO = 32'h0200_0000, ASET = 32'h0000_0800, PD = 32'h0800_0000;

  task automatic latch(int a);
    wr(5'h04, RDEN | 32'(a));
    wr(5'h04, RDEN | ASET | 32'(a));
    wr(5'h04, RDEN | 32'(a));
  endtask

  // start, then poll; returns the number of busy reads seen
  task automatic go_and_count(int a, output int n);
    logic [31:0] v;
    wr(5'h04, RDEN | GO | 32'(a));
    n = 0;
    for (int k = 0; k < LAT + 4; k++) begin
      rd(5'h04, v);
      if (v[26]) n++;
      if (k == 0 && k < 1) chk("R4 busy on first poll", 32'(v[26]), 32'd1);
    end
    wr(5'h04, RDEN | 32'(a));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(5'h04, v); chk("R1 ctrl", v, 32'h0800_0000);
    rd(5'h08, v); chk("R1 data", v, 32'h0);
    rd(5'h10, v); chk("R1 aux", v, 32'h0);

    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R9 aux only bit10", v, 32'h0000_0400);
    wr(5'h10, 32'h0);
    rd(5'h10, v); chk("R9 aux cleared", v, 32'h0);

    rd(5'h00, v); chk("R10 unmapped 0x00", v, 32'h0);
    rd(5'h0C, v); chk("R10 unmapped 0x0C", v, 32'h0);

    // start while powered down
    wr(5'h04, PD | RDEN | GO | 32'd3);
    rd(5'h04, v); chk("R8 start under power-down", 32'(v[26]), 32'd0);
    wr(5'h04, RDEN);

    // basic fetch of word 0
    latch(0);
    go_and_count(0, n);
    chk("R5 busy length", 32'(n), 32'(LAT));
    rd(5'h08, v); chk("R6 word 0", v, 32'hC9A4_7F5A);

    // upper-half word
    latch(100);
    go_and_count(100, n);
    rd(5'h08, v); chk("R6 word 100", v, ref_word(100));

    // read-enable clear
    wr(5'h04, GO | 32'd5);
    rd(5'h04, v); chk("R8 start without read-enable", 32'(v[26]), 32'd0);
    wr(5'h04, RDEN);
    rd(5'h08, v); chk("R8 data kept", v, ref_word(100));

    // repeated 1 on bit 25 without a 0 in between
    latch(7);
    wr(5'h04, RDEN | GO | 32'd7);
    repeat (LAT + 2) @(negedge clk);
    wr(5'h04, RDEN | GO | 32'd7);
    rd(5'h04, v); chk("R8 no re-trigger on held start", 32'(v[26]), 32'd0);
    rd(5'h08, v); chk("R6 word 7", v, ref_word(7));
    wr(5'h04, RDEN | 32'd7);

    // address field change and start while busy
    latch(20);
    wr(5'h04, RDEN | GO | 32'd20);
    wr(5'h04, RDEN | 32'd55);
    wr(5'h04, RDEN | ASET | 32'd60);
    wr(5'h04, RDEN | GO | 32'd60);
    repeat (LAT) @(negedge clk);
    rd(5'h04, v); chk("R8 start while busy ignored", 32'(v[26]), 32'd0);
    rd(5'h08, v); chk("R3 latched address kept", v, ref_word(20));
    wr(5'h04, RDEN | 32'd60);

    // out of range
    latch(200);
    go_and_count(200, n);
    rd(5'h08, v); chk("R7 out of range", v, 32'h0);
    latch(127);
    go_and_count(127, n);
    rd(5'h08, v); chk("R6 last word", v, ref_word(127));

    // data register write ignored
    wr(5'h08, 32'hDEAD_BEEF);
    rd(5'h08, v); chk("R10 data write ignored", v, ref_word(127));

    // stored programming fields and strobe readback
    wr(5'h04, 32'h0AAB_7ABC);
    rd(5'h04, v); chk("R2 readback", v, 32'h08AB_32BC);

    req = 0;
    @(negedge clk);
    chk("R11 idle bus", rdata, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule